// File: doc/BRIEF.md
# Four-Channel Multi-Mode DMA Engine

This block moves words for four independent channels over one simple word-wide memory port. Each channel holds a source pointer, a destination pointer, a word count, separate signed step values for each pointer, a control word and a done flag. Two registers are shared by all channels: a master control word that holds the global run bit, and a fill word. Three control bits pick the channel's mode. An I/O bit chooses device pacing or a free-running memory operation. A one-pointer bit chooses between one and two pointers. A four-bit request-source field names the pacing device.

The five modes are memory copy, memory fill, external single-pointer I/O, external two-pointer I/O and internal-peripheral I/O. A paced channel moves one word each time its selected request line is high, and it answers each word with a one-cycle acknowledge on that line's partner. A fixed priority chooses among pending channels, and channel 0 always wins. Each word runs to completion before the next grant. When a channel's count reaches zero, the channel sets its done flag, disarms itself and pulses its interrupt line.

Top module: `dma_engine`

## Requirements
- R1: After a synchronous reset, every register reads as zero, `mem_req` is low, and no interrupt or acknowledge line is high.
- R2: With the I/O bit (control bit 1) at 0 and the one-pointer bit (control bit 2) at 0, each word is a read at the source pointer. The next memory request is a write of that read data to the destination pointer.
- R3: With the I/O bit at 0 and the one-pointer bit at 1, the shared fill word is written at the source pointer. No read cycle occurs and the destination pointer is left unchanged.
- R4: With the I/O bit at 1, the one-pointer bit at 1 and source-field bit 3 at 0, each word is a single read cycle at the source pointer with no write, paced by `ext_dreq[c]`. The destination pointer is left unchanged.
- R5: With the I/O bit at 1, the one-pointer bit at 0 and source-field bit 3 at 0, each word is a read followed by a write, as in R2. A word starts only while `ext_dreq[c]` is high.
- R6: A source field of 10xx paces the channel from `sio_req` and acknowledges on `sio_ack`. A field of 11xx uses `aud_req` and `aud_ack`. Both internal kinds always use read-then-write with both pointers, whatever the one-pointer bit holds.
- R7: After every word, the source pointer advances by the source step. The destination pointer advances by the destination step whenever the mode uses it. Both additions wrap modulo 2^AW, so a step of all ones moves the pointer back by one.
- R8: The count drops by one per word. When it reaches zero, the channel sets its done flag (status bit 0), clears its enable bit (control bit 0) and pulses `irq[c]` for exactly one cycle.
- R9: A channel that is enabled with a count of zero moves no words and stays enabled.
- R10: When several channels are pending at a word boundary, the lowest-numbered one is granted.
- R11: No word starts while master bit 0 is 0. Clearing that bit lets the word in flight finish, then stops the engine. Setting it again resumes from the saved pointers and count.
- R12: Each word of a paced mode ends with a one-cycle pulse on exactly one acknowledge line, the one chosen by the source field. Memory modes give no acknowledge.
- R13: Register access uses a 6-bit word address. Bit 5 = 0 selects channel register file `addr[4:3]`, with offset `addr[2:0]`: 0 source, 1 destination, 2 count, 3 source step, 4 destination step, 5 control (bit 0 enable, bit 1 I/O, bit 2 one-pointer, bits 6:3 source field), 6 status (writing 1 to bit 0 clears done). Bit 5 = 1 selects offset 0 master and offset 1 fill word. `cfg_rdata` shows the addressed register one cycle after `cfg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data |
| mem_req | output | 1 | One-cycle memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| ext_dreq | input | 4 | External device request, one per channel |
| ext_dack | output | 4 | External device acknowledge pulse, one per channel |
| sio_req | input | 1 | Internal serial peripheral request |
| sio_ack | output | 1 | Internal serial peripheral acknowledge pulse |
| aud_req | input | 1 | Internal audio link request |
| aud_ack | output | 1 | Internal audio link acknowledge pulse |
| irq | output | 4 | Per-channel completion pulse |

## Verification
The assertions assume a synchronous memory that returns read data on the cycle after a read request. They also assume that a device holds its request until the acknowledge arrives and lowers it in the very next cycle. The interrupt property further assumes that software does not write a channel register on the edge where that channel finishes. To stay within these limits, the bench programs a channel only while the engine is idle or the channel is disarmed, and during activity it touches only the master word. Its memory model answers reads one cycle after the request, and its request tasks drop the request on the first low clock phase in which the acknowledge is seen.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [2:0] {
    MD_COPY,
    MD_FILL,
    MD_IO_SGL,
    MD_IO_DUAL,
    MD_IO_INT
  } xfer_mode_e;

  localparam logic [2:0] OFF_SRC  = 3'd0;
  localparam logic [2:0] OFF_DST  = 3'd1;
  localparam logic [2:0] OFF_CNT  = 3'd2;
  localparam logic [2:0] OFF_SINC = 3'd3;
  localparam logic [2:0] OFF_DINC = 3'd4;
  localparam logic [2:0] OFF_CTRL = 3'd5;
  localparam logic [2:0] OFF_STAT = 3'd6;

  function automatic xfer_mode_e decode_mode(input logic io, input logic sgl,
                                             input logic [3:0] sel);
    if (!io)        return sgl ? MD_FILL : MD_COPY;
    else if (sel[3]) return MD_IO_INT;
    else            return sgl ? MD_IO_SGL : MD_IO_DUAL;
  endfunction

  // modes that read the source and write the destination
  function automatic logic mode_two_ptr(input xfer_mode_e m);
    return (m == MD_COPY) || (m == MD_IO_DUAL) || (m == MD_IO_INT);
  endfunction

  function automatic logic mode_paced(input xfer_mode_e m);
    return (m == MD_IO_SGL) || (m == MD_IO_DUAL) || (m == MD_IO_INT);
  endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 32,
  localparam int WW = (AW > CW) ? AW : CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [2:0]    off,
  input  logic [WW-1:0] wr_data,
  input  logic          upd,
  input  logic          ext_req,
  input  logic          sio_req,
  input  logic          aud_req,
  output logic          pend,
  output xfer_mode_e    mode,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [3:0]    sel,
  output logic [DW-1:0] rd_data,
  output logic          irq
);

  logic [AW-1:0] sinc, dinc;
  logic [CW-1:0] cnt;
  logic          en, io, sgl, done;
  logic          req_in;

  assign mode   = decode_mode(io, sgl, sel);
  assign req_in = sel[3] ? (sel[2] ? aud_req : sio_req) : ext_req;
  assign pend   = en && (cnt != '0) && (!io || req_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      src  <= '0;
      dst  <= '0;
      sinc <= '0;
      dinc <= '0;
      cnt  <= '0;
      sel  <= '0;
      en   <= 1'b0;
      io   <= 1'b0;
      sgl  <= 1'b0;
      done <= 1'b0;
      irq  <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (upd) begin
        src <= src + sinc;
        if (mode_two_ptr(mode)) dst <= dst + dinc;
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          done <= 1'b1;
          en   <= 1'b0;
          irq  <= 1'b1;
        end
      end
      if (wr_en) begin
        case (off)
          OFF_SRC:  src  <= wr_data[AW-1:0];
          OFF_DST:  dst  <= wr_data[AW-1:0];
          OFF_CNT:  cnt  <= wr_data[CW-1:0];
          OFF_SINC: sinc <= wr_data[AW-1:0];
          OFF_DINC: dinc <= wr_data[AW-1:0];
          OFF_CTRL: {sel, sgl, io, en} <= wr_data[6:0];
          OFF_STAT: if (wr_data[0]) done <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (off)
      OFF_SRC:  rd_data[AW-1:0] = src;
      OFF_DST:  rd_data[AW-1:0] = dst;
      OFF_CNT:  rd_data[CW-1:0] = cnt;
      OFF_SINC: rd_data[AW-1:0] = sinc;
      OFF_DINC: rd_data[AW-1:0] = dinc;
      OFF_CTRL: rd_data[6:0]    = {sel, sgl, io, en};
      OFF_STAT: rd_data[0]      = done;
      default: ;
    endcase
  end

  // R8: a completion pulse coincides with a finished, disarmed channel
  a_r8_irq_done: assert property (@(posedge clk) disable iff (rst)
    irq |-> ((cnt == '0 && done && !en) || $past(wr_en)));

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] req,
  output logic           any,
  output logic [IW-1:0]  idx
);

  assign any = |req;

  always_comb begin
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 32,
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          gen,
  input  logic          any,
  input  logic [IW-1:0] gnt_idx,
  input  xfer_mode_e    g_mode,
  input  logic [AW-1:0] g_src,
  input  logic [AW-1:0] g_dst,
  input  logic [DW-1:0] fill,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          fin,
  output logic [IW-1:0] cur_ch,
  output xfer_mode_e    cur_mode
);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_CAP, S_LAST, S_GAP} seq_st_e;
  seq_st_e       st;
  logic [AW-1:0] dst_q;

  assign fin = (st == S_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      dst_q     <= '0;
      cur_ch    <= '0;
      cur_mode  <= MD_COPY;
    end else begin
      case (st)
        S_IDLE: if (gen && any) begin
          cur_ch   <= gnt_idx;
          cur_mode <= g_mode;
          dst_q    <= g_dst;
          mem_req  <= 1'b1;
          mem_addr <= g_src;
          if (mode_two_ptr(g_mode)) begin
            mem_we <= 1'b0;
            st     <= S_RD;
          end else if (g_mode == MD_FILL) begin
            mem_we    <= 1'b1;
            mem_wdata <= fill;
            st        <= S_LAST;
          end else begin
            mem_we <= 1'b0;
            st     <= S_LAST;
          end
        end
        S_RD: begin
          mem_req <= 1'b0;
          st      <= S_CAP;
        end
        S_CAP: begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= dst_q;
          mem_wdata <= mem_rdata;
          st        <= S_LAST;
        end
        S_LAST: begin
          mem_req <= 1'b0;
          st      <= S_GAP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2: every memory request lasts exactly one cycle
  a_r2_req_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
  // R11: an idle engine with the run bit low issues nothing
  a_r11_gen_gate: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && !gen) |=> !mem_req);
  // R3: fill never reads
  a_r3_fill_write_only: assert property (@(posedge clk) disable iff (rst)
    (mem_req && cur_mode == MD_FILL) |-> mem_we);
  // R4: single-pointer I/O never writes
  a_r4_single_no_write: assert property (@(posedge clk) disable iff (rst)
    (mem_req && cur_mode == MD_IO_SGL) |-> !mem_we);

endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int DW  = 32,
  parameter int CW  = 16,
  localparam int CHW    = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int CFG_AW = CHW + 4,
  localparam int WW     = (AW > CW) ? AW : CW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic [NCH-1:0]    ext_dreq,
  output logic [NCH-1:0]    ext_dack,
  input  logic              sio_req,
  output logic              sio_ack,
  input  logic              aud_req,
  output logic              aud_ack,
  output logic [NCH-1:0]    irq
);

  logic              gen;
  logic [DW-1:0]     fill_q;
  logic              shared_sel;
  logic [CHW-1:0]    ch_field;

  logic [NCH-1:0]    pend, upd;
  xfer_mode_e        ch_mode [NCH];
  logic [AW-1:0]     ch_src  [NCH];
  logic [AW-1:0]     ch_dst  [NCH];
  logic [3:0]        ch_sel  [NCH];
  logic [DW-1:0]     ch_rd   [NCH];

  logic              arb_any;
  logic [CHW-1:0]    arb_idx;
  logic              fin;
  logic [CHW-1:0]    cur_ch;
  xfer_mode_e        cur_mode;

  assign shared_sel = cfg_addr[CFG_AW-1];
  assign ch_field   = cfg_addr[CFG_AW-2:3];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dma_chan_regs #(.AW(AW), .CW(CW), .DW(DW)) u_regs (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (cfg_we && !shared_sel && ch_field == CHW'(i)),
      .off     (cfg_addr[2:0]),
      .wr_data (cfg_wdata[WW-1:0]),
      .upd     (upd[i]),
      .ext_req (ext_dreq[i]),
      .sio_req (sio_req),
      .aud_req (aud_req),
      .pend    (pend[i]),
      .mode    (ch_mode[i]),
      .src     (ch_src[i]),
      .dst     (ch_dst[i]),
      .sel     (ch_sel[i]),
      .rd_data (ch_rd[i]),
      .irq     (irq[i])
    );
    assign upd[i] = fin && (cur_ch == CHW'(i));
  end

  dma_prio_arb #(.NCH(NCH)) u_arb (
    .req (pend),
    .any (arb_any),
    .idx (arb_idx)
  );

  dma_seq #(.AW(AW), .DW(DW), .NCH(NCH)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .gen       (gen),
    .any       (arb_any),
    .gnt_idx   (arb_idx),
    .g_mode    (ch_mode[arb_idx]),
    .g_src     (ch_src[arb_idx]),
    .g_dst     (ch_dst[arb_idx]),
    .fill      (fill_q),
    .mem_rdata (mem_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .fin       (fin),
    .cur_ch    (cur_ch),
    .cur_mode  (cur_mode)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gen       <= 1'b0;
      fill_q    <= '0;
      cfg_rdata <= '0;
      ext_dack  <= '0;
      sio_ack   <= 1'b0;
      aud_ack   <= 1'b0;
    end else begin
      if (cfg_we && shared_sel) begin
        if (cfg_addr[2:0] == 3'd0) gen    <= cfg_wdata[0];
        if (cfg_addr[2:0] == 3'd1) fill_q <= cfg_wdata;
      end
      if (shared_sel) begin
        case (cfg_addr[2:0])
          3'd0:    cfg_rdata <= {{(DW-1){1'b0}}, gen};
          3'd1:    cfg_rdata <= fill_q;
          default: cfg_rdata <= '0;
        endcase
      end else begin
        cfg_rdata <= ch_rd[ch_field];
      end
      ext_dack <= '0;
      sio_ack  <= 1'b0;
      aud_ack  <= 1'b0;
      if (fin && mode_paced(cur_mode)) begin
        if (!ch_sel[cur_ch][3])     ext_dack[cur_ch] <= 1'b1;
        else if (ch_sel[cur_ch][2]) aud_ack <= 1'b1;
        else                        sio_ack <= 1'b1;
      end
    end
  end

  // R12: at most one acknowledge, and only right after a finished word
  a_r12_ack_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ext_dack, sio_ack, aud_ack}));
  a_r12_ack_after_word: assert property (@(posedge clk) disable iff (rst)
    (|{ext_dack, sio_ack, aud_ack}) |-> $past(fin));
  // R10: the granted channel is pending and no lower one is
  a_r10_grant_lowest: assert property (@(posedge clk) disable iff (rst)
    arb_any |-> (pend[arb_idx] &&
                 ((pend & ((NCH'(1) << arb_idx) - NCH'(1))) == '0)));

endmodule

// File: tb/tb_dma_engine.sv
module tb_dma_engine;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic [3:0]  ext_dreq = '0;
  logic [3:0]  ext_dack;
  logic        sio_req = 1'b0, sio_ack;
  logic        aud_req = 1'b0, aud_ack;
  logic [3:0]  irq;

  dma_engine dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .ext_dreq(ext_dreq), .ext_dack(ext_dack),
    .sio_req(sio_req), .sio_ack(sio_ack), .aud_req(aud_req),
    .aud_ack(aud_ack), .irq(irq)
  );

  always #4 clk = ~clk;

  // memory model: synchronous, read data one cycle after request
  logic [31:0] mem [256];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= 32'hA000_0000 | i;
      mem_rdata <= '0;
    end else if (mem_req) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[7:0]];
    end
  end

  // scoreboard
  logic [47:0] exp_q [$];
  logic [31:0] shadow [256];
  int n_checks = 0, n_errors = 0;
  int nwr = 0, nrd = 0;
  logic [15:0] last_raddr = '0;
  int dack_cnt [4];
  int irq_cnt [4];
  int sio_cnt = 0, aud_cnt = 0;
  string cur_req = "R1";
  bit done_run = 0;

  task automatic summary();
    if (!done_run) begin
      done_run = 1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  endtask

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual %0h expected %0h", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_req && mem_we) begin
        logic [47:0] e;
        nwr++;
        n_checks++;
        if (exp_q.size() == 0) begin
          n_errors++;
          $display("FAIL %s unexpected write actual %h:%h expected none",
                   cur_req, mem_addr, mem_wdata);
        end else begin
          e = exp_q.pop_front();
          if ({mem_addr, mem_wdata} !== e) begin
            n_errors++;
            $display("FAIL %s write actual %h:%h expected %h:%h",
                     cur_req, mem_addr, mem_wdata, e[47:32], e[31:0]);
          end
        end
      end
      if (mem_req && !mem_we) begin
        nrd++;
        last_raddr = mem_addr;
      end
      for (int i = 0; i < 4; i++) begin
        if (ext_dack[i]) dack_cnt[i]++;
        if (irq[i]) irq_cnt[i]++;
      end
      if (sio_ack) sio_cnt++;
      if (aud_ack) aud_cnt++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog actual hung expected finish");
    summary();
  end

  function automatic logic [5:0] ca(input int ch, input logic [2:0] off);
    return {1'b0, 2'(ch), off};
  endfunction
  localparam logic [5:0] MST  = 6'h20;
  localparam logic [5:0] FILL = 6'h21;

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic setup_ch(input int ch, input logic [15:0] s, input logic [15:0] d,
                          input logic [15:0] n, input logic [15:0] si, input logic [15:0] di);
    wr(ca(ch, 3'd0), {16'h0, s});
    wr(ca(ch, 3'd1), {16'h0, d});
    wr(ca(ch, 3'd2), {16'h0, n});
    wr(ca(ch, 3'd3), {16'h0, si});
    wr(ca(ch, 3'd4), {16'h0, di});
    wr(ca(ch, 3'd6), 32'h1);
  endtask

  task automatic push_copy(input logic [15:0] s, input logic [15:0] si,
                           input logic [15:0] d, input logic [15:0] di, input int n);
    for (int k = 0; k < n; k++) begin
      logic [15:0] a, b;
      a = 16'(s + k * si);
      b = 16'(d + k * di);
      exp_q.push_back({b, shadow[a[7:0]]});
      shadow[b[7:0]] = shadow[a[7:0]];
    end
  endtask

  task automatic push_fill(input logic [15:0] s, input logic [15:0] si,
                           input int n, input logic [31:0] v);
    for (int k = 0; k < n; k++) begin
      logic [15:0] a;
      a = 16'(s + k * si);
      exp_q.push_back({a, v});
      shadow[a[7:0]] = v;
    end
  endtask

  task automatic drain();
    int t = 0;
    while (exp_q.size() != 0 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    check({cur_req, " drain"}, 32'(exp_q.size()), 32'd0);
    repeat (12) @(negedge clk);
  endtask

  // raise a request line, wait for its acknowledge, then drop it
  task automatic serve(input int line);
    int t = 0;
    bit got = 0;
    @(negedge clk);
    if (line < 4) ext_dreq[line] = 1'b1;
    else if (line == 4) sio_req = 1'b1;
    else aud_req = 1'b1;
    while (!got && t < 500) begin
      @(negedge clk);
      t++;
      if (line < 4) got = ext_dack[line];
      else if (line == 4) got = sio_ack;
      else got = aud_ack;
    end
    ext_dreq = '0; sio_req = 1'b0; aud_req = 1'b0;
    check({cur_req, " ack seen"}, 32'(got), 32'd1);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    int w0, r0, w, rem;
    for (int i = 0; i < 256; i++) shadow[i] = 32'hA000_0000 | i;
    for (int i = 0; i < 4; i++) begin dack_cnt[i] = 0; irq_cnt[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R13 reset state
    cur_req = "R1";
    check("R1 mem_req", 32'(mem_req), 32'd0);
    check("R1 irq", 32'(irq), 32'd0);
    rd(ca(2, 3'd5), v); check("R1 ctrl", v, 32'd0);
    rd(MST, v);         check("R1 master", v, 32'd0);
    rd(ca(1, 3'd2), v); check("R13 count readback", v, 32'd0);

    // R11 no start with master off, then R2/R7/R8 copy
    cur_req = "R11";
    setup_ch(1, 16'h10, 16'h40, 16'd4, 16'd1, 16'd1);
    wr(ca(1, 3'd5), 32'h1);
    w0 = nwr;
    repeat (40) @(negedge clk);
    check("R11 idle while off", 32'(nwr - w0), 32'd0);
    cur_req = "R2";
    push_copy(16'h10, 16'd1, 16'h40, 16'd1, 4);
    wr(MST, 32'h1);
    drain();
    rd(ca(1, 3'd0), v); check("R7 src end", v, 32'h14);
    rd(ca(1, 3'd1), v); check("R7 dst end", v, 32'h44);
    rd(ca(1, 3'd2), v); check("R8 count zero", v, 32'd0);
    rd(ca(1, 3'd6), v); check("R8 done", v, 32'd1);
    rd(ca(1, 3'd5), v); check("R8 enable cleared", v, 32'd0);
    check("R8 irq once", 32'(irq_cnt[1]), 32'd1);
    check("R12 no ack in memory mode", 32'(dack_cnt[1]), 32'd0);

    // R7 negative step
    cur_req = "R7";
    setup_ch(0, 16'h50, 16'h7F, 16'd3, 16'd2, 16'hFFFF);
    push_copy(16'h50, 16'd2, 16'h7F, 16'hFFFF, 3);
    wr(ca(0, 3'd5), 32'h1);
    drain();
    rd(ca(0, 3'd1), v); check("R7 dst backwards", v, 32'h7C);

    // R3 fill
    cur_req = "R3";
    wr(FILL, 32'hDEAD_BEEF);
    setup_ch(2, 16'h90, 16'h33, 16'd3, 16'd3, 16'd1);
    push_fill(16'h90, 16'd3, 3, 32'hDEAD_BEEF);
    r0 = nrd;
    wr(ca(2, 3'd5), 32'h5);
    drain();
    check("R3 no reads", 32'(nrd - r0), 32'd0);
    rd(ca(2, 3'd1), v); check("R3 dst untouched", v, 32'h33);
    rd(ca(2, 3'd6), v); check("R3 done", v, 32'd1);

    // R10 priority: ch0 ahead of ch3
    cur_req = "R10";
    wr(MST, 32'h0);
    setup_ch(3, 16'hA0, 16'hC0, 16'd2, 16'd1, 16'd1);
    setup_ch(0, 16'hB0, 16'hD0, 16'd2, 16'd1, 16'd1);
    push_copy(16'hB0, 16'd1, 16'hD0, 16'd1, 2);
    push_copy(16'hA0, 16'd1, 16'hC0, 16'd1, 2);
    wr(ca(3, 3'd5), 32'h1);
    wr(ca(0, 3'd5), 32'h1);
    wr(MST, 32'h1);
    drain();

    // R9 zero count
    cur_req = "R9";
    setup_ch(1, 16'h10, 16'h40, 16'd0, 16'd1, 16'd1);
    w0 = nwr;
    wr(ca(1, 3'd5), 32'h1);
    repeat (30) @(negedge clk);
    check("R9 no words", 32'(nwr - w0), 32'd0);
    rd(ca(1, 3'd5), v); check("R9 still armed", v, 32'd1);
    wr(ca(1, 3'd5), 32'h0);

    // R11 stop mid-run and resume
    cur_req = "R11";
    setup_ch(0, 16'h00, 16'hE0, 16'd6, 16'd1, 16'd1);
    push_copy(16'h00, 16'd1, 16'hE0, 16'd1, 6);
    w0 = nwr;
    wr(ca(0, 3'd5), 32'h1);
    repeat (8) @(negedge clk);
    wr(MST, 32'h0);
    repeat (60) @(negedge clk);
    w = nwr - w0;
    rd(ca(0, 3'd2), v);
    rem = int'(v);
    check("R11 words+remaining", 32'(w + rem), 32'd6);
    check("R11 stopped early", 32'(rem > 0), 32'd1);
    check("R11 whole words", 32'(exp_q.size()), 32'(rem));
    repeat (40) @(negedge clk);
    check("R11 stays stopped", 32'(nwr - w0), 32'(w));
    wr(MST, 32'h1);
    drain();
    rd(ca(0, 3'd6), v); check("R11 resume done", v, 32'd1);

    // R5 external dual, paced
    cur_req = "R5";
    setup_ch(0, 16'h20, 16'h60, 16'd2, 16'd1, 16'd1);
    w0 = nwr;
    wr(ca(0, 3'd5), 32'h3);
    repeat (30) @(negedge clk);
    check("R5 waits for request", 32'(nwr - w0), 32'd0);
    for (int k = 0; k < 2; k++) begin
      push_copy(16'(16'h20 + k), 16'd1, 16'(16'h60 + k), 16'd1, 1);
      serve(0);
    end
    check("R5 two words", 32'(nwr - w0), 32'd2);
    check("R12 ext ack count", 32'(dack_cnt[0]), 32'd2);
    rd(ca(0, 3'd6), v); check("R5 done", v, 32'd1);

    // R4 external single pointer
    cur_req = "R4";
    setup_ch(1, 16'h30, 16'h70, 16'd2, 16'd1, 16'd1);
    r0 = nrd; w0 = nwr;
    wr(ca(1, 3'd5), 32'h7);
    serve(1);
    serve(1);
    check("R4 reads", 32'(nrd - r0), 32'd2);
    check("R4 last read addr", 32'(last_raddr), 32'h31);
    check("R4 no writes", 32'(nwr - w0), 32'd0);
    rd(ca(1, 3'd1), v); check("R4 dst untouched", v, 32'h70);
    check("R12 ext ack line 1", 32'(dack_cnt[1]), 32'd2);

    // R6 internal serial (one-pointer bit set, still dual)
    cur_req = "R6";
    setup_ch(2, 16'h38, 16'h78, 16'd1, 16'd1, 16'd1);
    push_copy(16'h38, 16'd1, 16'h78, 16'd1, 1);
    wr(ca(2, 3'd5), 32'h47);
    serve(4);
    rd(ca(2, 3'd1), v); check("R6 dst stepped", v, 32'h79);
    check("R12 sio ack", 32'(sio_cnt), 32'd1);

    // R6 internal audio
    setup_ch(3, 16'h3C, 16'h7C, 16'd1, 16'd1, 16'd1);
    push_copy(16'h3C, 16'd1, 16'h7C, 16'd1, 1);
    wr(ca(3, 3'd5), 32'h63);
    serve(5);
    check("R12 aud ack", 32'(aud_cnt), 32'd1);
    check("R12 sio unchanged", 32'(sio_cnt), 32'd1);
    check("R12 ext line 3 silent", 32'(dack_cnt[3]), 32'd0);
    check("R8 irq ch3", 32'(irq_cnt[3]), 32'd2);

    summary();
  end

endmodule